// File: doc/BRIEF.md
# Sixteen-Bit Adder-Shifter Datapath

This block is the register and arithmetic datapath that sits behind the control points of a small horizontally microcoded processor. Each clock carries out one microinstruction. The microinstruction opens gates from a set of source words onto two adder inputs. Either input can be inverted bitwise on its way in. The adder sum can be shifted by a single place, and the result is loaded into any chosen group of destination registers. A main-memory access then runs in the last phase of the same microinstruction.

There are ten 16-bit registers: four general registers, an index register, a memory address register, a memory buffer register, an instruction register, a program counter and a stack pointer. Five wired constants can also be gated onto either adder input. Memory reads always fill the buffer register from the address held in the address register. Memory writes send the buffer register to that address. The address and data seen by memory already include any load of those two registers made earlier in the same microinstruction. A selectable word and bit are brought out combinationally, so the sequencer can test a register bit for its conditional branches.

Top module: `uproc_datapath`

## Requirements
- R1: While rst_ni is low, all ten registers are zero, whether reset arrives at start-up or in the middle of a run.
- R2: Source indices map as follows: 0 A, 1 B, 2 C, 3 D, 4 X, 5 MAR, 6 MBR, 7 IR, 8 PC, 9 SP, 10 zero, 11 one, 12 all ones, 13 sign word (only bit 15 set), 14 the value 15. The five constants read back with these values.
- R3: Each adder input is the bitwise OR of every source whose bit in its gate vector is set. With no gate set the input is zero. The result is the 16-bit sum with the carry out discarded.
- R4: compl_a_i and compl_b_i invert their adder input bitwise after gating and before the add.
- R5: shift_i selects the post-add operation: 2'b01 shifts left one place with bit 0 filled by 0, 2'b10 shifts right one place with bit 15 filled by 0, and 2'b00 or 2'b11 leave the sum unshifted.
- R6: dst_en_i uses the R2 register indices 0..9. Every enabled register loads the same result at the clock edge, and every register that is not enabled keeps its value.
- R7: When a read is requested without a write, mem_re_o is high and mem_addr_o equals MAR as updated by the same microinstruction. MBR then loads mem_rdata_i, and this load overrides an ALU load of MBR.
- R8: When a write is requested, mem_we_o is high, and mem_addr_o and mem_wdata_o equal MAR and MBR as updated by the same microinstruction's ALU loads.
- R9: When a read and a write are both requested, the write proceeds, mem_re_o stays low, and MBR is not loaded from memory.
- R10: test_word_o is the source selected by test_sel_i under the R2 map, or zero for indices 15 and above. test_bit_o is bit test_bit_i of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one microinstruction per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_a_i | input | 15 | Source gates onto adder input A (R2 indices) |
| gate_b_i | input | 15 | Source gates onto adder input B (R2 indices) |
| compl_a_i | input | 1 | Invert adder input A |
| compl_b_i | input | 1 | Invert adder input B |
| shift_i | input | 2 | Post-add shift select |
| dst_en_i | input | 10 | Destination register load enables |
| mem_rd_i | input | 1 | Request memory read into MBR |
| mem_wr_i | input | 1 | Request memory write from MBR |
| mem_rdata_i | input | 16 | Read data from main memory |
| mem_addr_o | output | 16 | Memory address (post-ALU MAR) |
| mem_wdata_o | output | 16 | Memory write data (post-ALU MBR) |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| test_sel_i | input | 4 | Source index for the test port |
| test_bit_i | input | 4 | Bit index for the test port |
| test_word_o | output | 16 | Selected source word |
| test_bit_o | output | 1 | Selected bit of that word |

## Verification
The hardest case to reach is the ordering inside one microinstruction. Memory has to see an address or data word that the ALU is loading in that same cycle, and a memory read has to override an ALU load of MBR. The bench reaches this by first filling the registers with known values through the constants and a memory read. It then issues microinstructions that load MAR or MBR and start an access together, and checks the strobes, address and data in that cycle before the clock edge. The read-and-write conflict and the all-gates-off case are driven directly. Reset is applied again in the middle of the run to show that it clears registers already written.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int unsigned NUM_REGS   = 10;
  localparam int unsigned NUM_CONSTS = 5;
  localparam int unsigned NUM_SRCS   = NUM_REGS + NUM_CONSTS;
  localparam int unsigned SRC_W      = $clog2(NUM_SRCS + 1);

  typedef enum logic [3:0] {
    SRC_A     = 4'd0,
    SRC_B     = 4'd1,
    SRC_C     = 4'd2,
    SRC_D     = 4'd3,
    SRC_X     = 4'd4,
    SRC_MAR   = 4'd5,
    SRC_MBR   = 4'd6,
    SRC_IR    = 4'd7,
    SRC_PC    = 4'd8,
    SRC_SP    = 4'd9,
    SRC_ZERO  = 4'd10,
    SRC_ONE   = 4'd11,
    SRC_ONES  = 4'd12,
    SRC_SIGN  = 4'd13,
    SRC_FIFTN = 4'd14
  } src_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_KEEP  = 2'b11
  } shift_e;
endpackage

// File: rtl/dp_src_bus.sv
module dp_src_bus
  import dp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [NUM_SRCS-1:0][DATA_W-1:0] src_i,
  input  logic [NUM_SRCS-1:0]             gate_i,
  input  logic                            compl_i,
  output logic [DATA_W-1:0]               operand_o
);
  logic [NUM_SRCS-1:0][DATA_W-1:0] masked;
  logic [DATA_W-1:0]               bus_or;

  for (genvar i = 0; i < NUM_SRCS; i++) begin : g_mask
    assign masked[i] = src_i[i] & {DATA_W{gate_i[i]}};
  end

  // wired-OR bus: several open gates merge, none gives zero
  always_comb begin
    bus_or = '0;
    for (int i = 0; i < NUM_SRCS; i++) bus_or = bus_or | masked[i];
  end

  assign operand_o = compl_i ? ~bus_or : bus_or;
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [1:0]        shift_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] sum;
  shift_e            sh;

  assign sh  = shift_e'(shift_i);
  assign sum = op_a_i + op_b_i;  // carry out dropped

  always_comb begin
    unique case (sh)
      SH_LEFT:  result_o = {sum[DATA_W-2:0], 1'b0};
      SH_RIGHT: result_o = {1'b0, sum[DATA_W-1:1]};
      default:  result_o = sum;
    endcase
  end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile
  import dp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [DATA_W-1:0]               result_i,
  input  logic [NUM_REGS-1:0]             dst_en_i,
  input  logic                            mem_load_i,
  input  logic [DATA_W-1:0]               mem_rdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0] stage2_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_d;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    // value after the ALU write phase
    assign stage2_o[i] = dst_en_i[i] ? result_i : regs_q[i];

    if (i == int'(SRC_MBR)) begin : g_mbr
      // memory phase comes last and wins over the ALU load
      assign regs_d[i] = mem_load_i ? mem_rdata_i : stage2_o[i];
    end else begin : g_plain
      assign regs_d[i] = stage2_o[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[i] <= '0;
      else         regs_q[i] <= regs_d[i];
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/uproc_datapath.sv
module uproc_datapath
  import dp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned BIT_W = $clog2(DATA_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRCS-1:0] gate_a_i,
  input  logic [NUM_SRCS-1:0] gate_b_i,
  input  logic                compl_a_i,
  input  logic                compl_b_i,
  input  logic [1:0]          shift_i,
  input  logic [NUM_REGS-1:0] dst_en_i,
  input  logic                mem_rd_i,
  input  logic                mem_wr_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic [DATA_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                mem_re_o,
  output logic                mem_we_o,
  input  logic [SRC_W-1:0]    test_sel_i,
  input  logic [BIT_W-1:0]    test_bit_i,
  output logic [DATA_W-1:0]   test_word_o,
  output logic                test_bit_o
);
  function automatic logic [DATA_W-1:0] const_word(int unsigned k);
    unique case (k)
      0:       const_word = '0;
      1:       const_word = DATA_W'(1);
      2:       const_word = '1;
      3:       const_word = {1'b1, {(DATA_W-1){1'b0}}};
      default: const_word = DATA_W'(15);
    endcase
  endfunction

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_s2;
  logic [NUM_SRCS-1:0][DATA_W-1:0] src_words;
  logic [DATA_W-1:0]               op_a;
  logic [DATA_W-1:0]               op_b;
  logic [DATA_W-1:0]               alu_res;
  logic                            mem_load;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_src_reg
    assign src_words[r] = regs_q[r];
  end
  for (genvar k = 0; k < NUM_CONSTS; k++) begin : g_src_const
    assign src_words[NUM_REGS+k] = const_word(k);
  end

  dp_src_bus #(.DATA_W(DATA_W)) i_bus_a (
    .src_i    (src_words),
    .gate_i   (gate_a_i),
    .compl_i  (compl_a_i),
    .operand_o(op_a)
  );

  dp_src_bus #(.DATA_W(DATA_W)) i_bus_b (
    .src_i    (src_words),
    .gate_i   (gate_b_i),
    .compl_i  (compl_b_i),
    .operand_o(op_b)
  );

  dp_alu #(.DATA_W(DATA_W)) i_alu (
    .op_a_i  (op_a),
    .op_b_i  (op_b),
    .shift_i (shift_i),
    .result_o(alu_res)
  );

  // write has priority; a colliding read is dropped
  assign mem_load = mem_rd_i & ~mem_wr_i;

  dp_regfile #(.DATA_W(DATA_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .result_i   (alu_res),
    .dst_en_i   (dst_en_i),
    .mem_load_i (mem_load),
    .mem_rdata_i(mem_rdata_i),
    .regs_o     (regs_q),
    .stage2_o   (regs_s2)
  );

  // memory phase sees MAR/MBR after this microinstruction's ALU loads
  assign mem_addr_o  = regs_s2[SRC_MAR];
  assign mem_wdata_o = regs_s2[SRC_MBR];
  assign mem_re_o    = mem_load;
  assign mem_we_o    = mem_wr_i;

  always_comb begin
    test_word_o = '0;
    if (test_sel_i < SRC_W'(NUM_SRCS)) test_word_o = src_words[test_sel_i];
  end
  assign test_bit_o = test_word_o[test_bit_i];
endmodule

// File: rtl/dp_checker.sv
module dp_checker
  import dp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input logic [DATA_W-1:0]               result_i,
  input logic [DATA_W-1:0]               op_a_i,
  input logic [NUM_SRCS-1:0]             gate_a_i,
  input logic                            compl_a_i,
  input logic [1:0]                      shift_i,
  input logic [NUM_REGS-1:0]             dst_en_i,
  input logic                            mem_rd_i,
  input logic                            mem_wr_i,
  input logic                            mem_re_o,
  input logic                            mem_we_o,
  input logic [DATA_W-1:0]               mem_rdata_i
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg_chk
    if (i == int'(SRC_MBR)) begin : g_mbr
      assert_mbr_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dst_en_i[i] && !mem_re_o |=> regs_i[i] == $past(result_i));
      assert_mbr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dst_en_i[i] && !mem_re_o |=> $stable(regs_i[i]));
    end else begin : g_plain
      assert_reg_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dst_en_i[i] |=> regs_i[i] == $past(result_i));
      assert_reg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dst_en_i[i] |=> $stable(regs_i[i]));
    end
  end

  assert_read_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i && !mem_wr_i |=> regs_i[SRC_MBR] == $past(mem_rdata_i));

  assert_write_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o == mem_wr_i);

  assert_write_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i |-> !mem_re_o);

  assert_right_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i == 2'b10 |-> !result_i[DATA_W-1]);

  assert_left_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i == 2'b01 |-> !result_i[0]);

  assert_no_gate_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_a_i == '0 && !compl_a_i |-> op_a_i == '0);

  assert_no_gate_ones_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_a_i == '0 && compl_a_i |-> op_a_i == '1);
endmodule

bind uproc_datapath dp_checker #(.DATA_W(DATA_W)) i_dp_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .regs_i     (regs_q),
  .result_i   (alu_res),
  .op_a_i     (op_a),
  .gate_a_i   (gate_a_i),
  .compl_a_i  (compl_a_i),
  .shift_i    (shift_i),
  .dst_en_i   (dst_en_i),
  .mem_rd_i   (mem_rd_i),
  .mem_wr_i   (mem_wr_i),
  .mem_re_o   (mem_re_o),
  .mem_we_o   (mem_we_o),
  .mem_rdata_i(mem_rdata_i)
);

// File: tb/test_uproc_datapath.sv
module test_uproc_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] gate_a = '0, gate_b = '0;
  logic        compl_a = 1'b0, compl_b = 1'b0;
  logic [1:0]  shift = 2'b00;
  logic [9:0]  dst_en = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] mem_addr, mem_wdata, test_word;
  logic        mem_re, mem_we, test_bit_val;
  logic [3:0]  test_sel = '0, test_bit = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  uproc_datapath i_uproc_datapath (
    .clk_i(clk), .rst_ni(rst_n),
    .gate_a_i(gate_a), .gate_b_i(gate_b),
    .compl_a_i(compl_a), .compl_b_i(compl_b),
    .shift_i(shift), .dst_en_i(dst_en),
    .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .mem_rdata_i(mem_rdata),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_re_o(mem_re), .mem_we_o(mem_we),
    .test_sel_i(test_sel), .test_bit_i(test_bit),
    .test_word_o(test_word), .test_bit_o(test_bit_val)
  );

  typedef struct packed {
    logic [14:0] ga;
    logic [14:0] gb;
    logic        ca;
    logic        cb;
    logic [1:0]  sh;
    logic [9:0]  dst;
    logic        rd;
    logic [15:0] rdata;
    logic [3:0]  sel;
    logic [15:0] expv;
  } vec_t;

  // gate bits: A 0001 B 0002 C 0004 D 0008 MBR 0040 ZERO 0400 ONE 0800 ONES 1000 SIGN 2000 FIFTEEN 4000
  localparam vec_t VECS [15] = '{
    '{15'h0800, 15'h4000, 1'b0, 1'b0, 2'b00, 10'h001, 1'b0, 16'h0000, 4'd0,  16'h0010}, // R3 A=1+15
    '{15'h2000, 15'h0000, 1'b0, 1'b0, 2'b10, 10'h002, 1'b0, 16'h0000, 4'd1,  16'h4000}, // R5 right
    '{15'h0001, 15'h0002, 1'b0, 1'b0, 2'b01, 10'h004, 1'b0, 16'h0000, 4'd2,  16'h8020}, // R5 left
    '{15'h0001, 15'h0800, 1'b1, 1'b0, 2'b00, 10'h008, 1'b0, 16'h0000, 4'd3,  16'hFFF0}, // R4
    '{15'h1000, 15'h0800, 1'b0, 1'b0, 2'b00, 10'h010, 1'b0, 16'h0000, 4'd4,  16'h0000}, // R3 carry
    '{15'h0004, 15'h0008, 1'b0, 1'b0, 2'b00, 10'h020, 1'b0, 16'h0000, 4'd5,  16'h8010}, // R3
    '{15'h0000, 15'h0000, 1'b0, 1'b0, 2'b00, 10'h000, 1'b1, 16'h1234, 4'd6,  16'h1234}, // R7
    '{15'h0040, 15'h0800, 1'b0, 1'b0, 2'b00, 10'h180, 1'b0, 16'h0000, 4'd7,  16'h1235}, // R6 multi
    '{15'h0000, 15'h0000, 1'b0, 1'b0, 2'b00, 10'h000, 1'b0, 16'h0000, 4'd8,  16'h1235}, // R6
    '{15'h0400, 15'h0400, 1'b1, 1'b1, 2'b10, 10'h200, 1'b0, 16'h0000, 4'd9,  16'h7FFF}, // R4 R5
    '{15'h0001, 15'h0002, 1'b1, 1'b1, 2'b00, 10'h001, 1'b0, 16'h0000, 4'd0,  16'hBFEE}, // R4
    '{15'h4001, 15'h0400, 1'b0, 1'b0, 2'b00, 10'h002, 1'b0, 16'h0000, 4'd1,  16'hBFEF}, // R3 OR
    '{15'h0800, 15'h0800, 1'b0, 1'b0, 2'b11, 10'h004, 1'b0, 16'h0000, 4'd2,  16'h0002}, // R5 code 11
    '{15'h0000, 15'h0000, 1'b0, 1'b0, 2'b00, 10'h000, 1'b0, 16'h0000, 4'd13, 16'h8000}, // R2
    '{15'h0000, 15'h0000, 1'b0, 1'b0, 2'b00, 10'h000, 1'b0, 16'h0000, 4'd15, 16'h0000}  // R10
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic drive(input logic [14:0] ga, input logic [14:0] gb, input logic ca,
                       input logic cb, input logic [1:0] sh, input logic [9:0] dst,
                       input logic rd, input logic wr, input logic [15:0] rdata);
    gate_a = ga; gate_b = gb; compl_a = ca; compl_b = cb; shift = sh;
    dst_en = dst; mem_rd = rd; mem_wr = wr; mem_rdata = rdata;
  endtask

  task automatic peek(input logic [3:0] sel, input string req, input logic [15:0] expv);
    test_sel = sel;
    #1;
    chk(req, test_word, expv);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #25;
    for (int r = 0; r < 10; r++) peek(4'(r), "R1 reset", 16'h0000);
    peek(4'd10, "R2 zero", 16'h0000);
    peek(4'd11, "R2 one", 16'h0001);
    peek(4'd12, "R2 ones", 16'hFFFF);
    peek(4'd14, "R2 fifteen", 16'h000F);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < 15; v++) begin
      @(negedge clk);
      drive(VECS[v].ga, VECS[v].gb, VECS[v].ca, VECS[v].cb, VECS[v].sh,
            VECS[v].dst, VECS[v].rd, 1'b0, VECS[v].rdata);
      test_sel = VECS[v].sel;
      @(posedge clk);
      #2;
      chk($sformatf("R3-R6 vector %0d", v), test_word, VECS[v].expv);
    end

    @(negedge clk);
    drive('0, '0, 1'b0, 1'b0, 2'b00, '0, 1'b0, 1'b0, '0);
    // A = BFEE
    test_sel = 4'd0; test_bit = 4'd15; #1; chk("R10 bit15", 16'(test_bit_val), 16'h0001);
    test_bit = 4'd4; #1; chk("R10 bit4", 16'(test_bit_val), 16'h0000);
    peek(4'd3, "R6 D held", 16'hFFF0);

    // read with MAR loaded in the same microinstruction
    @(negedge clk);
    drive(15'h4000, '0, 1'b0, 1'b0, 2'b00, 10'h020, 1'b1, 1'b0, 16'hA5A5);
    #2;
    chk("R7 addr", mem_addr, 16'h000F);
    chk("R7 re", 16'(mem_re), 16'h0001);
    chk("R8 we idle", 16'(mem_we), 16'h0000);
    @(posedge clk); #2;
    peek(4'd6, "R7 mbr fill", 16'hA5A5);

    // read overrides ALU load of MBR
    @(negedge clk);
    drive(15'h0800, '0, 1'b0, 1'b0, 2'b00, 10'h040, 1'b1, 1'b0, 16'h0F0F);
    @(posedge clk); #2;
    peek(4'd6, "R7 override", 16'h0F0F);

    // write with MBR loaded in the same microinstruction
    @(negedge clk);
    drive(15'h0800, 15'h4000, 1'b0, 1'b0, 2'b00, 10'h040, 1'b0, 1'b1, 16'h0000);
    #2;
    chk("R8 we", 16'(mem_we), 16'h0001);
    chk("R8 wdata", mem_wdata, 16'h0010);
    chk("R8 addr", mem_addr, 16'h000F);
    @(posedge clk); #2;

    // read and write together: write wins
    @(negedge clk);
    drive('0, '0, 1'b0, 1'b0, 2'b00, '0, 1'b1, 1'b1, 16'hDEAD);
    #2;
    chk("R9 re low", 16'(mem_re), 16'h0000);
    chk("R9 we", 16'(mem_we), 16'h0001);
    chk("R9 wdata", mem_wdata, 16'h0010);
    @(posedge clk); #2;
    peek(4'd6, "R9 mbr kept", 16'h0010);

    @(negedge clk);
    drive('0, '0, 1'b0, 1'b0, 2'b00, '0, 1'b0, 1'b0, '0);
    rst_n = 1'b0;
    #2;
    peek(4'd0, "R1 mid-run A", 16'h0000);
    peek(4'd6, "R1 mid-run MBR", 16'h0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule